// File: doc/BRIEF.md
# Ethernet PAUSE Frame Detector

This block sits next to the receive path of a full-duplex Ethernet MAC. It watches each received frame one byte at a time and decides whether the frame is a MAC Control PAUSE request. It does this by position: it compares the destination address, the length/type word and the opcode with their required values, ignores the source address, and captures the 16-bit pause quanta. The frame is only reported once the end-of-frame status marks it as good and both mode enables are on. A report is a one-cycle `pause_detect` pulse, and `pause_quanta` carries the captured value in the same cycle. The transmit side can then hold off data frames for the requested time.

The receive byte stream is a valid-only stream. The detector takes every byte offered with `rx_valid` and never applies back-pressure, so it has no ready signal. `rx_sof` marks the first byte of a frame and is only meaningful together with `rx_valid`. `rx_eof` marks the end of a frame. It may arrive with the last byte or in a later cycle of its own, and `rx_good` is sampled in that same cycle. Bytes that arrive outside a frame (no start seen, or after an end) are ignored. CRC checking, hash filtering and storage of frame data are done elsewhere.

Top module: `pause_frame_detector`

## Requirements
- R1: Out of reset `pause_detect` is 0 and `pause_quanta` is 0x0000.
- R2: A frame whose bytes 0 to 5 are 0x01, 0x80, 0xC2, 0x00, 0x00, 0x01 passes the destination check. Any other value at those positions fails it, unless R3 applies.
- R3: A frame whose bytes 0 to 5 equal `station_addr`, with byte 0 taken from bits 47:40 and byte 5 from bits 7:0, passes the destination check.
- R4: Bytes 6 to 11 (the source address) have no effect on detection.
- R5: Bytes 12 and 13 must be 0x88 and 0x08, and bytes 14 and 15 must be 0x00 and 0x01. Any other value prevents detection.
- R6: Byte 16 (high) and byte 17 (low) form the pause quanta. Any value from 0x0000 to 0xFFFF is accepted and is presented on `pause_quanta`.
- R7: Detection needs `full_duplex_en` and `flow_ctrl_en` both high in the end-of-frame cycle.
- R8: Detection needs `rx_good` high in the end-of-frame cycle.
- R9: A frame that ends after fewer than 18 bytes is never reported. A frame of 18 or more bytes is reported when all the other conditions hold.
- R10: `pause_detect` is high for exactly the one cycle after the end-of-frame cycle. `pause_quanta` changes only in that cycle and otherwise holds the last reported value.
- R11: An `rx_sof` byte starts a new frame and discards all partial match state and the byte count of any unfinished frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | First byte of a frame (with rx_valid) |
| rx_valid | input | 1 | rx_data holds a received byte |
| rx_data | input | 8 | Received byte, wire order |
| rx_eof | input | 1 | End of the current frame |
| rx_good | input | 1 | Frame status, sampled with rx_eof |
| station_addr | input | 48 | Station unicast address, first wire byte in bits 47:40 |
| full_duplex_en | input | 1 | Full-duplex mode enable |
| flow_ctrl_en | input | 1 | Flow-control enable |
| pause_detect | output | 1 | One-cycle PAUSE detection pulse |
| pause_quanta | output | 16 | Pause quanta of the last detected frame |

## Verification
The byte count, the match flags and the captured quanta take in the byte of the current cycle combinationally. The only register between the end-of-frame cycle and the outputs is the output register. The pulse and the new quanta are therefore due exactly one cycle after the cycle that carries `rx_eof`. The bench drives on falling edges and samples on the falling edge that follows the `rx_eof` edge, which is where both results are due. One falling edge later it checks that the pulse has gone and that the quanta still hold. Rejected frames are checked at the same sampling point, so a late or early pulse shows up as a mismatch.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int TYPE_POS   = 12;
  localparam int OPC_POS    = 14;
  localparam int QUANTA_POS = 16;
  localparam int MIN_BYTES  = 18;
  localparam logic [47:0] CTRL_MCAST  = 48'h0180C2000001;
  localparam logic [15:0] CTRL_TYPE   = 16'h8808;
  localparam logic [15:0] CTRL_OPCODE = 16'h0001;

  typedef struct packed {
    logic mcast;
    logic ucast;
    logic ctrl;
  } match_t;
endpackage

// File: rtl/pfd_byte_counter.sv
module pfd_byte_counter #(
  parameter int LIMIT = 18,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             valid,
  input  logic             eof,
  output logic             start,
  output logic             take,
  output logic             in_frame,
  output logic [CNT_W-1:0] cur_idx,
  output logic [CNT_W-1:0] count_now
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT);

  logic [CNT_W-1:0] idx_q;
  logic             act_q;

  always_comb begin
    start    = sof & valid;
    cur_idx  = start ? '0 : idx_q;
    in_frame = start | act_q;
    take     = valid & in_frame;
    if (take)
      count_now = (cur_idx >= SAT) ? SAT : cur_idx + 1'b1;
    else
      count_now = cur_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= 1'b0;
    end else begin
      idx_q <= count_now;
      if (eof)
        act_q <= 1'b0;
      else if (start)
        act_q <= 1'b1;
    end
  end

  // R9
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= SAT);

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && valid && !eof) |=> (idx_q == CNT_W'(1)));
endmodule

// File: rtl/pfd_field_matcher.sv
module pfd_field_matcher
  import pfd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  input  logic [CNT_W-1:0] cur_idx,
  input  logic [7:0]       data,
  input  logic [47:0]      station_addr,
  output match_t           match_now,
  output logic [15:0]      quanta_now
);
  logic [7:0] mc_byte [ADDR_BYTES];
  logic [7:0] uc_byte [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign mc_byte[g] = CTRL_MCAST[47-8*g -: 8];
    assign uc_byte[g] = station_addr[47-8*g -: 8];
  end

  match_t      flags_q, base;
  logic [15:0] quanta_q, qbase;
  logic        hit_mc, hit_uc, hit_ctl;

  always_comb begin
    base   = start ? '{mcast: 1'b1, ucast: 1'b1, ctrl: 1'b1} : flags_q;
    qbase  = start ? 16'h0000 : quanta_q;
    hit_mc = 1'b1;
    hit_uc = 1'b1;
    hit_ctl = 1'b1;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (cur_idx == CNT_W'(i)) begin
        hit_mc = (data == mc_byte[i]);
        hit_uc = (data == uc_byte[i]);
      end
    end
    if (cur_idx == CNT_W'(TYPE_POS))      hit_ctl = (data == CTRL_TYPE[15:8]);
    if (cur_idx == CNT_W'(TYPE_POS + 1))  hit_ctl = (data == CTRL_TYPE[7:0]);
    if (cur_idx == CNT_W'(OPC_POS))       hit_ctl = (data == CTRL_OPCODE[15:8]);
    if (cur_idx == CNT_W'(OPC_POS + 1))   hit_ctl = (data == CTRL_OPCODE[7:0]);

    if (take) begin
      match_now.mcast = base.mcast & hit_mc;
      match_now.ucast = base.ucast & hit_uc;
      match_now.ctrl  = base.ctrl  & hit_ctl;
      quanta_now = qbase;
      if (cur_idx == CNT_W'(QUANTA_POS))     quanta_now[15:8] = data;
      if (cur_idx == CNT_W'(QUANTA_POS + 1)) quanta_now[7:0]  = data;
    end else begin
      match_now  = flags_q;
      quanta_now = quanta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q  <= '0;
      quanta_q <= '0;
    end else begin
      flags_q  <= match_now;
      quanta_q <= quanta_now;
    end
  end

  // R5
  ctrl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.ctrl) |-> $past(start));

  // R2
  mcast_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.mcast) |-> $past(start));
endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector
  import pfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_eof,
  input  logic        rx_good,
  input  logic [47:0] station_addr,
  input  logic        full_duplex_en,
  input  logic        flow_ctrl_en,
  output logic        pause_detect,
  output logic [15:0] pause_quanta
);
  localparam int CNT_W = $clog2(MIN_BYTES + 1);

  logic             start, take, in_frame;
  logic [CNT_W-1:0] cur_idx, count_now;
  match_t           match_now;
  logic [15:0]      quanta_now;
  logic             qualify;

  pfd_byte_counter #(.LIMIT(MIN_BYTES), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .sof(rx_sof), .valid(rx_valid), .eof(rx_eof),
    .start(start), .take(take), .in_frame(in_frame),
    .cur_idx(cur_idx), .count_now(count_now)
  );

  pfd_field_matcher #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take), .cur_idx(cur_idx),
    .data(rx_data), .station_addr(station_addr),
    .match_now(match_now), .quanta_now(quanta_now)
  );

  always_comb begin
    qualify = rx_eof & in_frame & rx_good & full_duplex_en & flow_ctrl_en
            & (match_now.mcast | match_now.ucast) & match_now.ctrl
            & (count_now >= CNT_W'(MIN_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_detect <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_detect <= qualify;
      if (qualify)
        pause_quanta <= quanta_now;
    end
  end

  // R7 R8
  detect_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_detect |-> $past(rx_eof && rx_good && full_duplex_en && flow_ctrl_en));

  // R10
  detect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_detect |=> !pause_detect);

  // R10
  quanta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_detect |-> $stable(pause_quanta));
endmodule

// File: tb/pause_frame_detector_tb_top.sv
module pause_frame_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [47:0] station_addr = 48'h0A1B2C3D4E5F;
  logic        full_duplex_en = 1'b1, flow_ctrl_en = 1'b1;
  logic        pause_detect;
  logic [15:0] pause_quanta;

  int total = 0;
  int fails = 0;
  logic [7:0]  fb [64];
  logic [15:0] last_q = 16'h0000;
  localparam logic [47:0] MC = 48'h0180C2000001;

  always #4 clk = ~clk;

  pause_frame_detector dut_i (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_good(rx_good),
    .station_addr(station_addr), .full_duplex_en(full_duplex_en),
    .flow_ctrl_en(flow_ctrl_en), .pause_detect(pause_detect),
    .pause_quanta(pause_quanta)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build(logic [47:0] da, logic [47:0] sa, logic [15:0] ty,
                       logic [15:0] op, logic [15:0] q);
    for (int i = 0; i < 64; i++) fb[i] = 8'h5A ^ 8'(i);
    for (int i = 0; i < 6; i++) begin
      fb[i]     = da[47-8*i -: 8];
      fb[6 + i] = sa[47-8*i -: 8];
    end
    fb[12] = ty[15:8]; fb[13] = ty[7:0];
    fb[14] = op[15:8]; fb[15] = op[7:0];
    fb[16] = q[15:8];  fb[17] = q[7:0];
  endtask

  task automatic play(int len, bit with_eof, bit good);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[i]; rx_sof = (i == 0);
      rx_eof = with_eof && (i == len - 1); rx_good = good;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
  endtask

  task automatic expect_result(bit exp, logic [15:0] q, string tag);
    chk(pause_detect == exp, tag, 32'(pause_detect), 32'(exp));
    if (exp) last_q = q;
    chk(pause_quanta == last_q, tag, 32'(pause_quanta), 32'(last_q));
    @(negedge clk);
    chk(pause_detect == 1'b0, "R10 pulse width", 32'(pause_detect), 0);
    chk(pause_quanta == last_q, "R10 quanta hold", 32'(pause_quanta), 32'(last_q));
  endtask

  task automatic frame(bit exp, logic [15:0] q, string tag);
    play(18, 1'b1, 1'b1);
    expect_result(exp, q, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pause_detect == 1'b0, "R1 detect in reset", 32'(pause_detect), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pause_detect == 1'b0, "R1 detect after reset", 32'(pause_detect), 0);
    chk(pause_quanta == 16'h0, "R1 quanta after reset", 32'(pause_quanta), 0);

    // R2 R6: multicast destination, quanta sweep (0, walking ones, all ones)
    for (int k = 0; k < 18; k++) begin
      logic [15:0] q;
      q = (k == 0) ? 16'h0000 : (k == 17) ? 16'hFFFF : 16'h1 << (k - 1);
      build(MC, 48'h112233445566, 16'h8808, 16'h0001, q);
      frame(1'b1, q, "R6 quanta sweep");
    end

    // R3: station address accepted, neighbour address rejected
    for (int k = 0; k < 4; k++) begin
      logic [15:0] q;
      q = 16'h1234 + 16'(k * 16'h1111);
      build(station_addr, 48'hFEDCBA987654, 16'h8808, 16'h0001, q);
      frame(1'b1, q, "R3 station address");
    end
    build(station_addr ^ 48'h1, 48'h0, 16'h8808, 16'h0001, 16'h7777);
    frame(1'b0, 16'h0, "R3 wrong address");

    // R2 R4 R5 R6: single-byte corruption sweep over bytes 0..17
    for (int idx = 0; idx < 18; idx++) begin
      bit exp;
      logic [15:0] q;
      build(MC, 48'h0, 16'h8808, 16'h0001, 16'hA5C3);
      fb[idx] = fb[idx] ^ 8'h10;
      exp = (idx >= 6 && idx <= 11) || idx >= 16;
      q = {fb[16], fb[17]};
      if (idx < 6)       frame(exp, q, "R2 corrupt destination");
      else if (idx < 12) frame(exp, q, "R4 corrupt source");
      else if (idx < 16) frame(exp, q, "R5 corrupt type/opcode");
      else               frame(exp, q, "R6 corrupt quanta");
    end
    for (int idx = 0; idx < 6; idx++) begin
      build(station_addr, 48'h0, 16'h8808, 16'h0001, 16'h0F0F);
      fb[idx] = fb[idx] ^ 8'h01;
      frame(1'b0, 16'h0, "R3 corrupt station byte");
    end

    // R7: enable combinations
    for (int e = 0; e < 4; e++) begin
      full_duplex_en = e[0];
      flow_ctrl_en   = e[1];
      build(MC, 48'h0, 16'h8808, 16'h0001, 16'(16'h0100 + e));
      frame(e == 3, 16'(16'h0100 + e), "R7 enables");
    end

    // R8: bad status
    build(MC, 48'h0, 16'h8808, 16'h0001, 16'h4242);
    play(18, 1'b1, 1'b0);
    expect_result(1'b0, 16'h0, "R8 bad status");

    // R9: length sweep
    for (int len = 1; len <= 26; len++) begin
      build(MC, 48'h0, 16'h8808, 16'h0001, 16'(16'h2000 + len));
      play(len, 1'b1, 1'b1);
      expect_result(len >= 18, 16'(16'h2000 + len), "R9 length");
    end

    // R11: restart discards partial state
    build(48'hFFFFFFFFFFFF, 48'h0, 16'h8808, 16'h0001, 16'h0);
    play(10, 1'b0, 1'b1);
    build(MC, 48'h0, 16'h8808, 16'h0001, 16'h3C3C);
    frame(1'b1, 16'h3C3C, "R11 restart after bad prefix");
    build(MC, 48'h0, 16'h0800, 16'h0001, 16'h0);
    play(14, 1'b0, 1'b1);
    build(station_addr, 48'h0, 16'h8808, 16'h0001, 16'hBEEF);
    frame(1'b1, 16'hBEEF, "R11 restart after bad type");
    build(MC, 48'h0, 16'h8808, 16'h0001, 16'h0);
    play(12, 1'b0, 1'b1);
    build(MC, 48'h0, 16'h8808, 16'h0001, 16'h5151);
    play(6, 1'b1, 1'b1);
    expect_result(1'b0, 16'h0, "R11 restart count cleared");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule